// File: doc/BRIEF.md
# Low-Power Stop and Wakeup Controller

This controller moves a processor subsystem into a low-power stop state and brings it back out. When a stop request strobe arrives, it captures the current 3-bit interrupt mask and a clock-keep configuration bit. It then removes the clock enable of the internal logic. It also removes the system clock enable, unless the captured configuration bit says that clock stays on. Finally, it turns off the bus, halt and spurious-interrupt monitors.

While stopped, the controller watches the priority levels of the interrupt request sources. The default has two sources: slot 0 is the periodic timer and slot 1 is the external request. A level of 0 means no request. Stop ends when any source's level exceeds the captured mask. A level-7 request always ends stop. Reset also ends stop at any time. All outputs come straight from registered state. A stimulus at one clock edge therefore shows on the outputs right after that edge.

Top module: `stop_wake_ctrl`

## Requirements
- R1: While reset is asserted and right after it, stop_active is 0 and core_clk_en, sys_clk_en and mon_en are all 1.
- R2: A stop_req high at a clock edge while running makes stop_active 1 and core_clk_en 0 from that edge on.
- R3: During stop, sys_clk_en equals the keep_sys_clk value sampled at the entry edge, and later changes of keep_sys_clk have no effect until the next entry.
- R4: mon_en is 0 exactly while stop_active is 1.
- R5: While stopped, if the highest request level is greater than the captured mask at a clock edge, stop_active drops to 0 and every enable returns to 1 at that edge.
- R6: While stopped, request levels at or below the captured mask, and any change of the irq_mask input, leave the block stopped.
- R7: A level-7 request wakes the block even when the captured mask is 7.
- R8: Either source wakes the block: slot 0 (bits 2:0 of req_lvls, periodic timer) or slot 1 (bits 5:3, external request).
- R9: If stop_req arrives while a request above the current mask is already pending, the block is stopped for exactly one cycle and wakes at the following edge.
- R10: Asserting rst_n low ends stop immediately, without waiting for a clock edge.
- R11: A stop_req during stop is ignored, and the captured mask is not replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of the controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Stop request strobe |
| irq_mask | input | 3 | Current interrupt priority mask |
| keep_sys_clk | input | 1 | 1 keeps the system clock enabled during stop |
| req_lvls | input | 6 | Request levels, 3 bits per source, 0 = none |
| core_clk_en | output | 1 | Clock enable for internal logic |
| sys_clk_en | output | 1 | System clock enable |
| mon_en | output | 1 | Enable for the bus, halt and spurious-interrupt monitors |
| stop_active | output | 1 | High while in the stop state |

## Verification
Entry, wakeup, the hold of the captured configuration and the ignored requests all show up one clock edge after the inputs are presented. The bench therefore drives each input set on a falling edge and compares all four outputs at the next falling edge. At that point the single intervening rising edge has been taken into account. Reset acts without a clock: its check samples one time unit after rst_n falls, in the middle of a clock phase, with no rising edge in between.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int unsigned LVL_W   = 3;
  localparam int unsigned MAX_LVL = (1 << LVL_W) - 1;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_STOP = 1'b1
  } swc_state_e;
endpackage

// File: rtl/swc_level_max.sv
module swc_level_max #(
  parameter int unsigned N_SRC = 2,
  parameter int unsigned LVL_W = 3
) (
  input  logic [N_SRC*LVL_W-1:0] lvls,
  output logic [LVL_W-1:0]       top_lvl
);
  logic [LVL_W-1:0] chain [N_SRC+1];

  assign chain[0] = '0;

  for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
    logic [LVL_W-1:0] cur;
    assign cur          = lvls[g*LVL_W +: LVL_W];
    assign chain[g + 1] = (cur > chain[g]) ? cur : chain[g];
  end

  assign top_lvl = chain[N_SRC];
endmodule

// File: rtl/swc_wake_qual.sv
module swc_wake_qual #(
  parameter int unsigned LVL_W = 3
) (
  input  logic [LVL_W-1:0] top_lvl,
  input  logic [LVL_W-1:0] ref_mask,
  output logic             hit
);
  localparam logic [LVL_W-1:0] NMI_LVL = {LVL_W{1'b1}};

  always_comb begin
    hit = (top_lvl > ref_mask) || (top_lvl == NMI_LVL);
  end
endmodule

// File: rtl/swc_stop_fsm.sv
module swc_stop_fsm
  import swc_pkg::*;
#(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic [LVL_W-1:0] irq_mask,
  input  logic             keep_sys_clk,
  input  logic             wake_hit,
  output logic             stopped,
  output logic             keep_held,
  output logic [LVL_W-1:0] mask_held
);
  swc_state_e       state_q, state_d;
  logic [LVL_W-1:0] mask_q, mask_d;
  logic             keep_q, keep_d;
  logic             cap_en;

  assign cap_en = (state_q == ST_RUN) && stop_req;

  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    keep_d  = keep_q;
    unique case (state_q)
      ST_RUN: begin
        if (cap_en) begin
          state_d = ST_STOP;
          mask_d  = irq_mask;
          keep_d  = keep_sys_clk;
        end
      end
      ST_STOP: begin
        if (wake_hit) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      mask_q  <= '0;
      keep_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        mask_q <= mask_d;
        keep_q <= keep_d;
      end
    end
  end

  assign stopped   = (state_q == ST_STOP);
  assign keep_held = keep_q;
  assign mask_held = mask_q;

  // R11: captured mask is frozen while stop persists
  a_r11_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && $past(stopped)) |-> $stable(mask_q));
  // R3: captured configuration bit is frozen while stop persists
  a_r3_keep_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && $past(stopped)) |-> $stable(keep_q));
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swc_pkg::*;
#(
  parameter int unsigned N_SRC = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stop_req,
  input  logic [LVL_W-1:0]       irq_mask,
  input  logic                   keep_sys_clk,
  input  logic [N_SRC*LVL_W-1:0] req_lvls,
  output logic                   core_clk_en,
  output logic                   sys_clk_en,
  output logic                   mon_en,
  output logic                   stop_active
);
  logic [LVL_W-1:0] top_lvl;
  logic [LVL_W-1:0] mask_held;
  logic             keep_held;
  logic             wake_hit;
  logic             stopped;

  swc_level_max #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_max (
    .lvls    (req_lvls),
    .top_lvl (top_lvl)
  );

  swc_wake_qual #(.LVL_W(LVL_W)) u_qual (
    .top_lvl  (top_lvl),
    .ref_mask (mask_held),
    .hit      (wake_hit)
  );

  swc_stop_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_req     (stop_req),
    .irq_mask     (irq_mask),
    .keep_sys_clk (keep_sys_clk),
    .wake_hit     (wake_hit),
    .stopped      (stopped),
    .keep_held    (keep_held),
    .mask_held    (mask_held)
  );

  assign stop_active = stopped;
  assign core_clk_en = !stopped;
  assign sys_clk_en  = !stopped || keep_held;
  assign mon_en      = !stopped;

  // R2: request while running enters stop at the next edge
  a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_active && stop_req) |=> (stop_active && !core_clk_en));
  // R5: a qualifying level ends stop at the next edge
  a_r5_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_active && (top_lvl > mask_held)) |=> (!stop_active && core_clk_en && sys_clk_en));
  // R6: no qualifying level keeps the block stopped
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_active && !wake_hit) |=> stop_active);
  // R7: the top level always ends stop
  a_r7_top_level: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_active && (top_lvl == LVL_W'(MAX_LVL))) |=> !stop_active);
  // R4: monitors off exactly during stop
  a_r4_monitors: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mon_en, stop_active}) && (mon_en || stop_active));
endmodule

// File: tb/sim_stop_wake_ctrl.sv
module sim_stop_wake_ctrl;
  localparam int CLK_P = 10;
  localparam int NV    = 15;

  // {stop_req, mask[2:0], keep, lvl0[2:0], lvl1[2:0], exp_stop, exp_sys}
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 3'd0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1},
    {1'b1, 3'd3, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0},
    {1'b0, 3'd0, 1'b1, 3'd2, 3'd3, 1'b1, 1'b0},
    {1'b1, 3'd0, 1'b1, 3'd1, 3'd1, 1'b1, 1'b0},
    {1'b0, 3'd0, 1'b1, 3'd2, 3'd2, 1'b1, 1'b0},
    {1'b0, 3'd0, 1'b1, 3'd0, 3'd4, 1'b0, 1'b1},
    {1'b1, 3'd4, 1'b1, 3'd0, 3'd0, 1'b1, 1'b1},
    {1'b0, 3'd4, 1'b0, 3'd4, 3'd0, 1'b1, 1'b1},
    {1'b0, 3'd4, 1'b0, 3'd5, 3'd0, 1'b0, 1'b1},
    {1'b1, 3'd7, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0},
    {1'b0, 3'd7, 1'b0, 3'd6, 3'd6, 1'b1, 1'b0},
    {1'b0, 3'd7, 1'b0, 3'd0, 3'd7, 1'b0, 1'b1},
    {1'b1, 3'd2, 1'b0, 3'd3, 3'd0, 1'b1, 1'b0},
    {1'b0, 3'd2, 1'b0, 3'd3, 3'd0, 1'b0, 1'b1},
    {1'b0, 3'd0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stop_req;
  logic [2:0] irq_mask;
  logic       keep_sys_clk;
  logic [5:0] req_lvls;
  logic       core_clk_en, sys_clk_en, mon_en, stop_active;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  stop_wake_ctrl u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_req     (stop_req),
    .irq_mask     (irq_mask),
    .keep_sys_clk (keep_sys_clk),
    .req_lvls     (req_lvls),
    .core_clk_en  (core_clk_en),
    .sys_clk_en   (sys_clk_en),
    .mon_en       (mon_en),
    .stop_active  (stop_active)
  );

  function automatic string tag_of(int i);
    case (i)
      1:       return "R2";
      2:       return "R6/R3";
      3, 4:    return "R11";
      5:       return "R5/R8";
      6:       return "R3";
      7:       return "R6";
      8:       return "R8";
      10:      return "R6";
      11:      return "R7";
      12, 13:  return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: {stop,core,sys,mon} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_outs(string tag, logic es, logic ey);
    chk(tag, {stop_active, core_clk_en, sys_clk_en, mon_en}, {es, !es, ey, !es});
  endtask

  initial begin
    #(CLK_P*5000);
    n_errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stop_req = 1'b0; irq_mask = '0; keep_sys_clk = 1'b0; req_lvls = '0;
    #(CLK_P*2 + 1);
    chk_outs("R1 during reset", 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_outs("R1 after reset", 1'b0, 1'b1);

    // table walk: drive at falling edge, check at next falling edge (R4 on every row)
    for (int i = 0; i < NV; i++) begin
      stop_req     = VEC[i][12];
      irq_mask     = VEC[i][11:9];
      keep_sys_clk = VEC[i][8];
      req_lvls     = {VEC[i][4:2], VEC[i][7:5]};
      @(negedge clk);
      chk_outs(tag_of(i), VEC[i][1], VEC[i][0]);
    end

    // R10: asynchronous reset ends stop without a clock edge
    stop_req = 1'b1; irq_mask = 3'd7; keep_sys_clk = 1'b0; req_lvls = '0;
    @(negedge clk);
    stop_req = 1'b0;
    chk_outs("R2 entry before reset", 1'b1, 1'b0);
    #1 rst_n = 1'b0;
    #1;
    chk_outs("R10 async exit", 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_outs("R1 after second reset", 1'b0, 1'b1);

    // R7 with mask 7 and only slot 0 at level 7
    stop_req = 1'b1; irq_mask = 3'd7;
    @(negedge clk);
    stop_req = 1'b0; req_lvls = 6'b000_111;
    @(negedge clk);
    chk_outs("R7 slot0 level7", 1'b0, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule